// File: doc/BRIEF.md
# PWM Start-High Synchronization Sequencer

This block sits next to a free-running 16-bit PWM timer whose counter restarts at FFFCh, whose period is set by a second compare value and whose pulse edge is set by a first compare value. Each compare value has its own output-level bit, applied to the PWM pin when the counter matches it. If such a timer is simply started, the pin waits a whole period for its first high phase. When `start_i` is pulsed, the sequencer reprograms the timer so that the pin goes high on the first counts after the counter is cleared. It then puts the real compare values and levels back at fixed counter milestones.

The sequencer owns the timer's two compare values, both level bits and the counter-clear strobe, and watches the live counter. `mode_i` selects the pulse placement. Mode 0 (lead) is high from the restart point until compare 1 and low until compare 2. Mode 1 (mid) is low from the restart point and high between compare 1 and compare 2. `period_i` is the compare-2 value and `high_i` is the high-time count. The sequencer derives the compare-1 value itself: `high_i` in lead mode, `period_i - high_i` in mid mode. Before the first start it holds the timer at 0% duty. `busy_o` marks the window from the counter clear to the last restore write.

States: `ST_ZERO_DUTY` (reset, 0% duty, following the inputs), `ST_LOAD_TEMP` (temporary values written), `ST_WAIT_LOW` (clear issued, waiting for the upper counter half to read zero), `ST_WAIT_WRAP` (mid mode only, waiting for the counter MSB after the next restart) and `ST_RUN` (real values in place). Transitions:
- start accepted: `ST_ZERO_DUTY` or `ST_RUN` to `ST_LOAD_TEMP`.
- clear issued: `ST_LOAD_TEMP` to `ST_WAIT_LOW`.
- low milestone: `ST_WAIT_LOW` to `ST_RUN` in lead mode, or to `ST_WAIT_WRAP` in mid mode.
- wrap milestone: `ST_WAIT_WRAP` to `ST_RUN`.

Top module: `pwm_start_sync`

## Requirements
- R1: After reset `busy_o` and `clr_o` are 0. In `ST_ZERO_DUTY` the outputs follow the inputs one cycle later. In lead mode (`mode_i`=0) both levels are 0, `cmp1_o`=`high_i` and `cmp2_o`=`period_i`. In mid mode (`mode_i`=1) `lvl1_o`=1, `lvl2_o`=0, `cmp1_o`=`period_i`+1 and `cmp2_o`=`period_i`.
- R2: A start sampled in `ST_ZERO_DUTY` or `ST_RUN` writes the temporary values in the next cycle: `cmp1_o`=FFFDh, `lvl1_o`=1, `lvl2_o`=0. `cmp2_o` becomes `period_i` in lead mode, and FFFDh+`high_i` modulo 2^16 in mid mode (the carry out of bit 15 is dropped).
- R3: `clr_o` is a single-cycle pulse in the cycle after the temporary values appear, and `busy_o` rises in that same cycle.
- R4: In lead mode, on the edge after the counter's upper byte is first seen as zero, `cmp1_o`=`high_i`, `lvl1_o`=0 and `lvl2_o`=1 appear, and `busy_o` falls in the same cycle.
- R5: In mid mode, on the edge after the counter's upper byte is first seen as zero, `cmp1_o` becomes `period_i - high_i`. `cmp2_o` keeps its temporary value and `busy_o` stays 1.
- R6: In mid mode, after the R5 write, on the edge after counter bit 15 is first seen set, `cmp2_o` returns to `period_i` and `busy_o` falls.
- R7: A start is ignored in `ST_LOAD_TEMP` and while `busy_o` is 1. Mode, period and high time are captured at the accepted start, so input changes during the sequence have no effect.
- R8: The counter value seen during the `clr_o` cycle is not used for any milestone.
- R9: `lvl1_o` and `lvl2_o` are never both 1.
- R10: With a timer that clears to FFFCh, the PWM pin is already high when the counter reads FFFEh, in both modes. In mid mode this needs `high_i` of at least 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart request |
| mode_i | input | 1 | 0 = lead (high from restart until compare 1), 1 = mid (high between compare 1 and compare 2) |
| period_i | input | 16 | Target compare-2 (period) value |
| high_i | input | 16 | High-time count |
| cnt_i | input | 16 | Live timer counter |
| cmp1_o | output | 16 | Compare-1 value for the timer |
| cmp2_o | output | 16 | Compare-2 value for the timer |
| lvl1_o | output | 1 | Level applied on a compare-1 match |
| lvl2_o | output | 1 | Level applied on a compare-2 match |
| clr_o | output | 1 | Counter clear strobe (timer loads FFFCh) |
| busy_o | output | 1 | Synchronization in progress |

## Verification
A wrong state or a missing milestone guard shows up within a few cycles of the clear. The compare-1 value leaves FFFDh one cycle after the clear instead of four to five cycles later, or it never leaves it, and `busy_o` hangs high. A mixed-up mode register shows up as swapped level bits, or as compare 2 being restored before compare 1, on the restore edge. The bench therefore runs a timer and pin model and checks the exact counter value seen on the edge before each restore. It also checks the pin level at FFFEh and counts clear pulses when start is held high during a sequence.

// File: rtl/pwmsync_pkg.sv
package pwmsync_pkg;

    typedef enum logic [2:0] {
        ST_ZERO_DUTY = 3'd0,
        ST_LOAD_TEMP = 3'd1,
        ST_WAIT_LOW  = 3'd2,
        ST_WAIT_WRAP = 3'd3,
        ST_RUN       = 3'd4
    } seq_state_t;

    typedef enum logic {
        MODE_LEAD = 1'b0,
        MODE_MID  = 1'b1
    } lvl_mode_t;

endpackage

// File: rtl/pwmsync_calc.sv
module pwmsync_calc
    import pwmsync_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  lvl_mode_t          mode_i,
    input  logic [CNT_W-1:0]   period_i,
    input  logic [CNT_W-1:0]   high_i,
    output logic [CNT_W-1:0]   temp_cmp1_o,
    output logic [CNT_W-1:0]   temp_cmp2_o,
    output logic [CNT_W-1:0]   rest_cmp1_o,
    output logic [CNT_W-1:0]   idle_cmp1_o,
    output logic               idle_lvl1_o,
    output logic               idle_lvl2_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] RESTART  = ALL_ONES - CNT_W'(3);
    localparam logic [CNT_W-1:0] TEMP_C1  = RESTART + CNT_W'(1);

    always_comb begin
        temp_cmp1_o = TEMP_C1;
        if (mode_i == MODE_MID) begin
            // plain modular add: carry out of the top bit is dropped
            temp_cmp2_o = TEMP_C1 + high_i;
            rest_cmp1_o = period_i - high_i;
            idle_cmp1_o = period_i + CNT_W'(1);
            idle_lvl1_o = 1'b1;
            idle_lvl2_o = 1'b0;
        end else begin
            temp_cmp2_o = period_i;
            rest_cmp1_o = high_i;
            idle_cmp1_o = high_i;
            idle_lvl1_o = 1'b0;
            idle_lvl2_o = 1'b0;
        end
    end

endmodule

// File: rtl/pwmsync_milestone.sv
module pwmsync_milestone #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ignore_i,
    output logic             low_hit_o,
    output logic             wrap_hit_o
);
    localparam int HALF = CNT_W / 2;

    logic [HALF-1:0] upper;
    logic            unused_low;

    assign upper      = cnt_i[CNT_W-1:HALF];
    assign unused_low = ^cnt_i[HALF-1:0];

    // the counter seen during the clear cycle is stale, so drop it
    assign low_hit_o  = !ignore_i && (upper == '0);
    assign wrap_hit_o = !ignore_i && cnt_i[CNT_W-1];

endmodule

// File: rtl/pwmsync_fsm.sv
module pwmsync_fsm
    import pwmsync_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  lvl_mode_t        mode_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             low_hit_i,
    input  logic             wrap_hit_i,
    input  logic [CNT_W-1:0] temp_cmp1_i,
    input  logic [CNT_W-1:0] temp_cmp2_i,
    input  logic [CNT_W-1:0] rest_cmp1_i,
    input  logic [CNT_W-1:0] idle_cmp1_i,
    input  logic             idle_lvl1_i,
    input  logic             idle_lvl2_i,
    output logic [CNT_W-1:0] cmp1_o,
    output logic [CNT_W-1:0] cmp2_o,
    output logic             lvl1_o,
    output logic             lvl2_o,
    output logic             clr_o,
    output logic             busy_o
);
    seq_state_t       state_q, state_n;
    lvl_mode_t        mode_q;
    logic [CNT_W-1:0] rest1_q;
    logic [CNT_W-1:0] period_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ZERO_DUTY;
        else        state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_ZERO_DUTY, ST_RUN: if (start_i) state_n = ST_LOAD_TEMP;
            ST_LOAD_TEMP:         state_n = ST_WAIT_LOW;
            ST_WAIT_LOW: if (low_hit_i)
                state_n = (mode_q == MODE_MID) ? ST_WAIT_WRAP : ST_RUN;
            ST_WAIT_WRAP: if (wrap_hit_i) state_n = ST_RUN;
            default:              state_n = ST_ZERO_DUTY;
        endcase
    end

    // outputs and captured targets
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp1_o   <= '0;
            cmp2_o   <= '0;
            lvl1_o   <= 1'b0;
            lvl2_o   <= 1'b0;
            clr_o    <= 1'b0;
            busy_o   <= 1'b0;
            mode_q   <= MODE_LEAD;
            rest1_q  <= '0;
            period_q <= '0;
        end else begin
            clr_o <= 1'b0;
            unique case (state_q)
                ST_ZERO_DUTY, ST_RUN: begin
                    if (start_i) begin
                        cmp1_o   <= temp_cmp1_i;
                        cmp2_o   <= temp_cmp2_i;
                        lvl1_o   <= 1'b1;
                        lvl2_o   <= 1'b0;
                        mode_q   <= mode_i;
                        rest1_q  <= rest_cmp1_i;
                        period_q <= period_i;
                    end else if (state_q == ST_ZERO_DUTY) begin
                        cmp1_o <= idle_cmp1_i;
                        cmp2_o <= period_i;
                        lvl1_o <= idle_lvl1_i;
                        lvl2_o <= idle_lvl2_i;
                    end
                end
                ST_LOAD_TEMP: begin
                    clr_o  <= 1'b1;
                    busy_o <= 1'b1;
                end
                ST_WAIT_LOW: begin
                    if (low_hit_i) begin
                        cmp1_o <= rest1_q;
                        if (mode_q == MODE_LEAD) begin
                            lvl1_o <= 1'b0;
                            lvl2_o <= 1'b1;
                            busy_o <= 1'b0;
                        end
                    end
                end
                ST_WAIT_WRAP: begin
                    if (wrap_hit_i) begin
                        cmp2_o <= period_q;
                        busy_o <= 1'b0;
                    end
                end
                default: begin
                    busy_o <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwm_start_sync.sv
module pwm_start_sync
    import pwmsync_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cmp1_o,
    output logic [CNT_W-1:0] cmp2_o,
    output logic             lvl1_o,
    output logic             lvl2_o,
    output logic             clr_o,
    output logic             busy_o
);
    lvl_mode_t        mode_e;
    logic [CNT_W-1:0] temp_cmp1, temp_cmp2, rest_cmp1, idle_cmp1;
    logic             idle_lvl1, idle_lvl2;
    logic             low_hit, wrap_hit;

    assign mode_e = lvl_mode_t'(mode_i);

    pwmsync_calc #(.CNT_W(CNT_W)) calc_i (
        .mode_i      (mode_e),
        .period_i    (period_i),
        .high_i      (high_i),
        .temp_cmp1_o (temp_cmp1),
        .temp_cmp2_o (temp_cmp2),
        .rest_cmp1_o (rest_cmp1),
        .idle_cmp1_o (idle_cmp1),
        .idle_lvl1_o (idle_lvl1),
        .idle_lvl2_o (idle_lvl2)
    );

    pwmsync_milestone #(.CNT_W(CNT_W)) mile_i (
        .cnt_i      (cnt_i),
        .ignore_i   (clr_o),
        .low_hit_o  (low_hit),
        .wrap_hit_o (wrap_hit)
    );

    pwmsync_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_e),
        .period_i    (period_i),
        .low_hit_i   (low_hit),
        .wrap_hit_i  (wrap_hit),
        .temp_cmp1_i (temp_cmp1),
        .temp_cmp2_i (temp_cmp2),
        .rest_cmp1_i (rest_cmp1),
        .idle_cmp1_i (idle_cmp1),
        .idle_lvl1_i (idle_lvl1),
        .idle_lvl2_i (idle_lvl2),
        .cmp1_o      (cmp1_o),
        .cmp2_o      (cmp2_o),
        .lvl1_o      (lvl1_o),
        .lvl2_o      (lvl2_o),
        .clr_o       (clr_o),
        .busy_o      (busy_o)
    );

endmodule

// File: rtl/pwm_start_sync_chk.sv
module pwm_start_sync_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] cmp1_o,
    input logic             lvl1_o,
    input logic             lvl2_o,
    input logic             clr_o,
    input logic             busy_o
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] TEMP_C1  = ALL_ONES - CNT_W'(2);

    logic unused_low;
    assign unused_low = ^cnt_i[HALF-1:0];

    assert_temp_before_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> (cmp1_o == TEMP_C1 && lvl1_o && !lvl2_o));

    assert_single_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !clr_o);

    assert_busy_with_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> clr_o);

    assert_lead_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && lvl2_o) |-> ($past(cnt_i[CNT_W-1:HALF]) == '0));

    assert_mid_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !lvl2_o) |-> $past(cnt_i[CNT_W-1]));

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> !clr_o);

    assert_stale_count_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_o) |-> (cmp1_o == TEMP_C1));

    assert_levels_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lvl1_o, lvl2_o}));

endmodule

bind pwm_start_sync pwm_start_sync_chk #(.CNT_W(CNT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_i  (cnt_i),
    .cmp1_o (cmp1_o),
    .lvl1_o (lvl1_o),
    .lvl2_o (lvl2_o),
    .clr_o  (clr_o),
    .busy_o (busy_o)
);

// File: tb/pwm_start_sync_tb_top.sv
module pwm_start_sync_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [15:0] period_i = 16'h005F;
    logic [15:0] high_i = 16'h002D;
    logic [15:0] cnt;
    logic [15:0] cmp1_o, cmp2_o;
    logic        lvl1_o, lvl2_o, clr_o, busy_o;
    logic        pwm;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pwm_start_sync dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .period_i(period_i), .high_i(high_i), .cnt_i(cnt),
        .cmp1_o(cmp1_o), .cmp2_o(cmp2_o), .lvl1_o(lvl1_o), .lvl2_o(lvl2_o),
        .clr_o(clr_o), .busy_o(busy_o)
    );

    // timer model: clear loads FFFCh, compare-2 match restarts at FFFCh
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= 16'h0000;
        else if (clr_o)          cnt <= 16'hFFFC;
        else if (cnt == cmp2_o)  cnt <= 16'hFFFC;
        else                     cnt <= cnt + 16'd1;
    end

    // pin model
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pwm <= 1'b0;
        else if (cnt == cmp1_o)  pwm <= lvl1_o;
        else if (cnt == cmp2_o)  pwm <= lvl2_o;
    end

    // {mode, period, high, expected restored compare 1, expected temporary compare 2}
    localparam logic [64:0] VECS [5] = '{
        {1'b0, 16'h005F, 16'h002D, 16'h002D, 16'h005F},
        {1'b1, 16'h005F, 16'h000F, 16'h0050, 16'h000C},
        {1'b1, 16'h0100, 16'h0005, 16'h00FB, 16'h0002},
        {1'b0, 16'h0200, 16'h0001, 16'h0001, 16'h0200},
        {1'b1, 16'h0040, 16'h0010, 16'h0030, 16'h000D}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    task automatic run_seq(input logic [64:0] v);
        logic        m;
        logic [15:0] per, hi, e1, e2, prev;
        logic        done, c1_seen, hi_seen;
        string       rt;
        m = v[64]; per = v[63:48]; hi = v[47:32]; e1 = v[31:16]; e2 = v[15:0];
        rt = m ? "R6" : "R4";
        @(negedge clk);
        mode_i = m; period_i = per; high_i = hi; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 temp cmp1", cmp1_o, 16'hFFFD);
        chk("R2 temp cmp2", cmp2_o, e2);
        chk("R2 temp levels", {lvl1_o, lvl2_o}, 2'b10);
        chk("R3 no clear yet", clr_o, 1'b0);
        @(negedge clk);
        chk("R3 clear pulse", clr_o, 1'b1);
        chk("R3 busy with clear", busy_o, 1'b1);
        @(negedge clk);
        chk("R3 clear single", clr_o, 1'b0);
        chk("R8 stale count ignored", cmp1_o, 16'hFFFD);
        prev = cnt; done = 1'b0; c1_seen = 1'b0; hi_seen = 1'b0;
        for (int k = 0; k < 400 && !done; k++) begin
            @(negedge clk);
            if (cnt == 16'hFFFE && !hi_seen) begin
                hi_seen = 1'b1;
                chk("R10 pin high at FFFE", pwm, 1'b1);
            end
            if (m && !c1_seen && cmp1_o != 16'hFFFD) begin
                c1_seen = 1'b1;
                chk("R5 cmp1 restored", cmp1_o, e1);
                chk("R5 cmp2 still temp", cmp2_o, e2);
                chk("R5 busy held", busy_o, 1'b1);
                chk("R5 restore at zero", prev, 16'h0000);
            end
            if (!busy_o) begin
                done = 1'b1;
                chk({rt, " final cmp1"}, cmp1_o, e1);
                chk({rt, " final cmp2"}, cmp2_o, per);
                chk({rt, " final levels"}, {lvl1_o, lvl2_o}, {m, ~m});
                chk({rt, " milestone count"}, prev, m ? 16'hFFFC : 16'h0000);
            end
            prev = cnt;
        end
        chk({rt, " sequence ended"}, done, 1'b1);
    endtask

    initial begin
        // R1: reset and 0% duty configuration
        #3;
        chk("R1 busy in reset", busy_o, 1'b0);
        chk("R1 clear in reset", clr_o, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 lead idle levels", {lvl1_o, lvl2_o}, 2'b00);
        chk("R1 lead idle cmp1", cmp1_o, 16'h002D);
        chk("R1 lead idle cmp2", cmp2_o, 16'h005F);
        chk("R1 busy idle", busy_o, 1'b0);
        mode_i = 1'b1; high_i = 16'h000F;
        @(negedge clk);
        chk("R1 mid idle levels", {lvl1_o, lvl2_o}, 2'b10);
        chk("R1 mid idle cmp1", cmp1_o, 16'h0060);
        chk("R1 mid idle cmp2", cmp2_o, 16'h005F);
        chk("R1 idle pin low", pwm, 1'b0);

        // table walk (R2..R6, R8, R10)
        for (int i = 0; i < 5; i++) begin
            run_seq(VECS[i]);
            repeat (5) @(negedge clk);
        end

        // R7: start held through the sequence, inputs changed while busy
        begin
            int  clears;
            logic fin;
            clears = 0; fin = 1'b0;
            @(negedge clk);
            mode_i = 1'b1; period_i = 16'h005F; high_i = 16'h000F; start_i = 1'b1;
            for (int k = 0; k < 400 && !fin; k++) begin
                @(negedge clk);
                if (clr_o) clears++;
                if (k == 4) begin
                    start_i = 1'b0;
                    period_i = 16'h0077;
                    high_i = 16'h0003;
                    mode_i = 1'b0;
                end
                if (k > 2 && !busy_o) fin = 1'b1;
            end
            chk("R7 single clear", clears, 1);
            chk("R7 captured cmp1", cmp1_o, 16'h0050);
            chk("R7 captured cmp2", cmp2_o, 16'h005F);
            chk("R7 captured levels", {lvl1_o, lvl2_o}, 2'b10);
            repeat (3) @(negedge clk);
            chk("R7 no late start", busy_o, 1'b0);
        end

        finish_run();
    end

endmodule